// File: doc/BRIEF.md
# Partitioned Modulo Data-RAM Addresser

This block turns a per-instruction word offset into a physical data-RAM address for a DSP engine that processes audio one sample at a time. The RAM is split at run time into two regions. The lower region is circular. A rotating base pointer moves forward by one word at each sample-period strobe, and every offset aimed at this region is added to that base and folded back inside the region. This lets delay lines and filter histories shift each period without any data being moved. The upper region is addressed absolutely: its addresses never rotate, so a value stored there in one sample period can be read back unchanged in any later period.

The split point comes from a size input counted in blocks of 512 words. The full array holds 20,480 words (40 blocks), and after reset the whole array is circular. A new size is taken in only at the next sample strobe, and that strobe restarts the base pointer at zero. Each request gives one registered result on the following clock: either a valid address or a range-error flag.

Top module: `modram_addresser`

## Requirements
- R1: After reset, the active size is 40 blocks (the whole 20,480-word RAM is circular), the base pointer is 0, and `addrValid`, `rangeErr` and `addr` are all 0.
- R2: With an active size of N blocks (after clamping), the circular region covers addresses 0 to N*512-1 and the absolute region begins at address N*512. Example: N=2 gives a circular region of 0..1023 and an absolute region from 1024.
- R3: A circular request (`regionFixed`=0) with `offset` below the circular size M returns address (base + offset) mod M.
- R4: Each `sampleStrobe` that does not change the size moves the base pointer forward by one. When the pointer reaches M it wraps to 0.
- R5: An absolute request (`regionFixed`=1) returns M + `offset`, and the result does not depend on the base pointer or on any number of strobes.
- R6: A circular request with `offset` >= M, or an absolute request with M + `offset` >= 20,480, gives `rangeErr`=1, `addrValid`=0 and `addr`=0.
- R7: A change on `sizeBlocks` has no effect until the next `sampleStrobe`. At that strobe the new size becomes active and the base pointer is set to 0 (it does not advance).
- R8: Results appear on the clock after the request. A cycle with no request gives `addrValid`=0 and `rangeErr`=0. A request made in the same cycle as a strobe uses the base pointer value from before that strobe.
- R9: A `sizeBlocks` value above 40 is treated as 40. A size of 0 makes every circular request a range error, and the absolute region then starts at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sizeBlocks | input | 6 | Requested circular-region size in 512-word blocks |
| sampleStrobe | input | 1 | One-cycle pulse at the end of each sample period |
| reqValid | input | 1 | An address request is present this cycle |
| regionFixed | input | 1 | 1 selects the absolute region, 0 the circular region |
| offset | input | 15 | Word offset inside the selected region |
| addr | output | 15 | Physical RAM address (registered) |
| addrValid | output | 1 | `addr` holds a valid result for last cycle's request |
| rangeErr | output | 1 | Last cycle's request was out of range |

## Verification
A base pointer that is off by one shows up on the very next circular request: the returned address moves by the same amount, one clock after that request. A wrong count of strobes only shows once a request follows. A wrong active size shows in two places: absolute addresses move by whole 512-word blocks, and the point where errors begin moves, both one clock after the affected request. A size that is taken in too early, or a base that is not cleared at the size-change strobe, is caught by requests made just before and just after that strobe. A fault in the wrap logic appears only at the strobe where the pointer reaches the top of the region, so the bench drives a small region through complete rotations.

// File: rtl/modram_pkg.sv
package modram_pkg;

  // strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic advance;   // step the rotating base by one word
    logic restart;   // new size taken in: base goes back to zero
  } seqStrobes_t;

endpackage

// File: rtl/modram_ctrl.sv
module modram_ctrl
  import modram_pkg::*;
#(
  parameter int NUM_BLOCKS  = 40,
  parameter int BLOCK_WORDS = 512,
  parameter int SIZE_W      = $clog2(NUM_BLOCKS + 1),
  parameter int ADDR_W      = $clog2(NUM_BLOCKS * BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SIZE_W-1:0] sizeBlocks,
  input  logic              sampleStrobe,
  output seqStrobes_t       strobes,
  output logic [ADDR_W:0]   modWords
);

  localparam int BLOCK_SHIFT = $clog2(BLOCK_WORDS);
  localparam logic [SIZE_W-1:0] MAX_BLOCKS = SIZE_W'(NUM_BLOCKS);

  logic [SIZE_W-1:0] activeSize;
  logic [SIZE_W-1:0] sizeClamped;
  logic              sizeChange;

  always_comb begin
    if (sizeBlocks > MAX_BLOCKS) sizeClamped = MAX_BLOCKS;
    else                         sizeClamped = sizeBlocks;
  end

  assign sizeChange = (sizeClamped != activeSize);

  always_comb begin
    strobes         = '0;
    strobes.restart = sampleStrobe && sizeChange;
    strobes.advance = sampleStrobe && !sizeChange && (activeSize != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSize <= MAX_BLOCKS;
    end else if (strobes.restart) begin
      activeSize <= sizeClamped;
    end
  end

  assign modWords = (ADDR_W + 1)'(activeSize) << BLOCK_SHIFT;

  // R9: the active size never goes past the array
  a_r9_size_clamped: assert property (@(posedge clk) disable iff (!rstN)
    activeSize <= MAX_BLOCKS);

  // R7: the size only moves on a strobe
  a_r7_size_holds: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(activeSize));

  // R4/R7: at most one action per strobe
  a_r4_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.advance, strobes.restart}));

endmodule

// File: rtl/modram_datapath.sv
module modram_datapath
  import modram_pkg::*;
#(
  parameter int NUM_BLOCKS  = 40,
  parameter int BLOCK_WORDS = 512,
  parameter int ADDR_W      = $clog2(NUM_BLOCKS * BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W:0]   modWords,
  input  logic              reqValid,
  input  logic              regionFixed,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic              rangeErr
);

  localparam int WIDE_W = ADDR_W + 2;
  localparam logic [WIDE_W-1:0] TOTAL_WORDS = WIDE_W'(NUM_BLOCKS * BLOCK_WORDS);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   baseInc;
  logic [ADDR_W:0]   modSum;
  logic [ADDR_W:0]   modWrap;
  logic              modOk;
  logic [WIDE_W-1:0] fixedSum;
  logic              fixedOk;
  logic              hitOk;
  logic [ADDR_W-1:0] hitAddr;

  // rotating base pointer
  assign baseInc = {1'b0, base} + (ADDR_W + 1)'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base <= '0;
    end else if (strobes.restart) begin
      base <= '0;
    end else if (strobes.advance) begin
      if (baseInc == modWords) base <= '0;
      else                     base <= baseInc[ADDR_W-1:0];
    end
  end

  // circular region: fold base + offset back into [0, modWords)
  assign modOk   = ({1'b0, offset} < modWords);
  assign modSum  = {1'b0, base} + {1'b0, offset};
  assign modWrap = (modSum >= modWords) ? (modSum - modWords) : modSum;

  // absolute region: start of upper region plus offset, no folding
  assign fixedSum = WIDE_W'(modWords) + WIDE_W'(offset);
  assign fixedOk  = (fixedSum < TOTAL_WORDS);

  always_comb begin
    if (regionFixed) begin
      hitOk   = fixedOk;
      hitAddr = fixedSum[ADDR_W-1:0];
    end else begin
      hitOk   = modOk;
      hitAddr = modWrap[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr      <= '0;
      addrValid <= 1'b0;
      rangeErr  <= 1'b0;
    end else begin
      addrValid <= reqValid && hitOk;
      rangeErr  <= reqValid && !hitOk;
      addr      <= (reqValid && hitOk) ? hitAddr : '0;
    end
  end

  // R4: the base stays inside the circular region
  a_r4_base_in_region: assert property (@(posedge clk) disable iff (!rstN)
    (modWords != '0) |-> ({1'b0, base} < modWords));

  // R9: an empty circular region keeps the base at zero
  a_r9_base_zero_empty: assert property (@(posedge clk) disable iff (!rstN)
    (modWords == '0) |-> (base == '0));

  // R7: a size change restarts rotation from zero
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (base == '0));

  // R3: circular results land inside the circular region
  a_r3_mod_in_region: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !regionFixed && strobes == '0) |=>
      (!addrValid || ({1'b0, addr} < modWords)));

  // R5: absolute results land at or above the region split
  a_r5_fixed_above: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && regionFixed && strobes == '0) |=>
      (!addrValid || ({1'b0, addr} >= modWords)));

  // R6: a result is never both valid and in error, and errors give address 0
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && rangeErr) && (!rangeErr || addr == '0));

endmodule

// File: rtl/modram_addresser.sv
module modram_addresser
  import modram_pkg::*;
#(
  parameter int NUM_BLOCKS  = 40,
  parameter int BLOCK_WORDS = 512,
  parameter int SIZE_W      = $clog2(NUM_BLOCKS + 1),
  parameter int ADDR_W      = $clog2(NUM_BLOCKS * BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SIZE_W-1:0] sizeBlocks,
  input  logic              sampleStrobe,
  input  logic              reqValid,
  input  logic              regionFixed,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic              rangeErr
);

  seqStrobes_t     strobes;
  logic [ADDR_W:0] modWords;

  modram_ctrl #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_WORDS(BLOCK_WORDS),
    .SIZE_W     (SIZE_W),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sizeBlocks  (sizeBlocks),
    .sampleStrobe(sampleStrobe),
    .strobes     (strobes),
    .modWords    (modWords)
  );

  modram_datapath #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_WORDS(BLOCK_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .modWords   (modWords),
    .reqValid   (reqValid),
    .regionFixed(regionFixed),
    .offset     (offset),
    .addr       (addr),
    .addrValid  (addrValid),
    .rangeErr   (rangeErr)
  );

  // R8: no request, no result on the next clock
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!addrValid && !rangeErr));

  // R8: a request always yields exactly one kind of result
  a_r8_one_result: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (addrValid != rangeErr));

endmodule

// File: tb/modram_addresser_bench.sv
`timescale 1ns/1ps
module modram_addresser_bench;

  localparam int TOTAL = 20480;
  localparam int BLK   = 512;
  localparam int MAXB  = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  sizeBlocks = 6'd40;
  logic        sampleStrobe = 1'b0;
  logic        reqValid = 1'b0;
  logic        regionFixed = 1'b0;
  logic [14:0] offset = '0;
  logic [14:0] addr;
  logic        addrValid;
  logic        rangeErr;

  always #4 clk = ~clk;

  modram_addresser u_modram_addresser (
    .clk(clk), .rstN(rstN), .sizeBlocks(sizeBlocks), .sampleStrobe(sampleStrobe),
    .reqValid(reqValid), .regionFixed(regionFixed), .offset(offset),
    .addr(addr), .addrValid(addrValid), .rangeErr(rangeErr)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  // behavioural reference state
  int mActive = MAXB;
  int mBase = 0;
  int expAddr = 0;
  int expValid = 0;
  int expErr = 0;

  task automatic compare();
    checks++;
    if (int'(addr) != expAddr || int'(addrValid) != expValid || int'(rangeErr) != expErr) begin
      failures++;
      $display("FAIL %s: addr=%0d valid=%0d err=%0d expected addr=%0d valid=%0d err=%0d",
               curReq, addr, addrValid, rangeErr, expAddr, expValid, expErr);
    end
  endtask

  task automatic model(input int sz, input bit stb, input bit req, input bit fx, input int off);
    int clampSz;
    int mw;
    int a;
    clampSz = (sz > MAXB) ? MAXB : sz;
    mw = mActive * BLK;
    expAddr = 0; expValid = 0; expErr = 0;
    if (req) begin
      if (fx) begin
        a = mw + off;
        if (a < TOTAL) begin expValid = 1; expAddr = a; end
        else expErr = 1;
      end else begin
        if (off < mw) begin expValid = 1; expAddr = (mBase + off) % mw; end
        else expErr = 1;
      end
    end
    if (stb) begin
      if (clampSz != mActive) begin mActive = clampSz; mBase = 0; end
      else if (mw > 0) mBase = (mBase + 1) % mw;
    end
  endtask

  // one clock: check last result, drive new inputs, advance the model
  task automatic step(input int sz, input bit stb, input bit req, input bit fx, input int off);
    @(negedge clk);
    compare();
    sizeBlocks   = 6'(sz);
    sampleStrobe = stb;
    reqValid     = req;
    regionFixed  = fx;
    offset       = 15'(off);
    model(sz, stb, req, fx, off);
  endtask

  initial begin
    #(200000 * 8);
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int sz;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, then an idle cycle
    curReq = "R1";
    step(40, 0, 0, 0, 0);
    step(40, 0, 0, 0, 0);

    // R3: default whole-RAM circular region with a few strobes
    curReq = "R3";
    step(40, 0, 1, 0, 0);
    step(40, 0, 1, 0, 20479);
    step(40, 1, 0, 0, 0);
    step(40, 1, 0, 0, 0);
    step(40, 0, 1, 0, 20479);
    step(40, 0, 1, 0, 100);

    // R6: absolute region empty at full size, circular offset past top
    curReq = "R6";
    step(40, 0, 1, 1, 0);
    step(40, 0, 1, 0, 20480);
    step(40, 0, 1, 0, 32767);

    // R7: size change waits for strobe, base cleared at that strobe
    curReq = "R7";
    step(2, 0, 1, 0, 5000);
    step(2, 0, 1, 1, 0);
    step(2, 1, 0, 0, 0);
    step(2, 0, 1, 0, 0);
    step(2, 0, 1, 0, 1023);

    // R2: split at 1024
    curReq = "R2";
    step(2, 0, 1, 1, 0);
    step(2, 0, 1, 0, 1024);
    step(2, 0, 1, 1, 19455);
    step(2, 0, 1, 1, 19456);

    // R5: absolute addresses ignore strobes
    curReq = "R5";
    for (int i = 0; i < 5; i++) step(2, 1, 0, 0, 0);
    step(2, 0, 1, 1, 77);
    step(2, 1, 1, 1, 77);
    step(2, 0, 1, 1, 77);

    // R8: request together with a strobe sees pre-strobe base
    curReq = "R8";
    step(2, 1, 1, 0, 10);
    step(2, 0, 1, 0, 10);
    step(2, 0, 0, 1, 5);

    // R4: full rotations of a one-block region
    curReq = "R4";
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 1100; i++) step(1, 1, (i % 3) == 0, 0, (i * 37) % 512);
    step(1, 0, 1, 0, 511);

    // R9: clamping and the empty circular region
    curReq = "R9";
    step(63, 1, 0, 0, 0);
    step(63, 0, 1, 1, 0);
    step(63, 0, 1, 0, 20479);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 1, 5);
    step(0, 1, 1, 1, 20479);
    step(0, 0, 1, 1, 20480);

    // R3: mixed traffic across sizes
    curReq = "R3";
    sz = 7;
    for (int i = 0; i < 3000; i++) begin
      if (i % 700 == 0) sz = (sz * 5 + 3) % 45;
      step(sz, (i % 4) == 1, (i % 2) == 0, (i % 5) == 0, (i * 2311) % 24000);
    end

    step(sz, 0, 0, 0, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule